// File: doc/BRIEF.md
# Electronic Dice Sequencer

This block is the random source for an electronic die. It holds a three-bit face value that is always one of the codes 1 to 6. While the active-low play button is held, the value steps through the six faces in ascending order, one face per clock, and goes back to 1 after 6. When the button is let go the value freezes, and that frozen value is the throw.

The clock is fast compared with a human press, so a player cannot steer the outcome. The result depends only on how many clock edges the press lasted. The button input is asynchronous to the clock. It passes through a chain of synchronising flops, which reset to the released level, before the state machine acts on it. The face output goes to a separate pip decoder.

Top module: `dice_roller`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `face` to 1 after that edge and sets the synchroniser to the released level.
- R2: `face` only ever shows the binary codes 1, 2, 3, 4, 5 or 6. The codes 0 and 7 never appear on the output. An illegal state code would return to 1 on the next clock.
- R3: While the synchronised button reads held, `face` goes up by exactly one at each rising edge, in the order 1, 2, 3, 4, 5, 6.
- R4: Stepping from face 6 gives face 1.
- R5: While the synchronised button reads released (`play_n` = 1), `face` keeps its value.
- R6: With the default two synchroniser stages, the level of `play_n` sampled at rising edge k decides whether `face` steps at edge k+2. A press held for N sampled edges therefore gives exactly N steps, and those steps finish two edges after release.
- R7: A reset applied while the button is held returns `face` to 1. The first step after reset then comes only once the held level has passed through both synchroniser stages again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast stepping clock |
| rst | input | 1 | Synchronous reset, active high |
| play_n | input | 1 | Play button, 0 = held, asynchronous to `clk` |
| face | output | 3 | Current face code, 1 to 6 |

## Verification
The bench builds the block with its defaults: six faces and two synchroniser stages, which give a three-bit output. With six faces a hold of a dozen edges wraps through 6 to 1 twice, so the wrap is exercised many times inside a short run. The two-stage latency lets the bench confirm the exact count of steps for single-edge taps, presses across a reset, and a long pseudo-random press pattern.

// File: rtl/dice_pkg.sv
package dice_pkg;

    // Level of the active-low play button after synchronisation.
    typedef enum logic {
        BTN_HELD = 1'b0,
        BTN_FREE = 1'b1
    } btn_e;

endpackage

// File: rtl/dice_sync.sv
module dice_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    import dice_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.chain = {STAGES{BTN_FREE}};
        end else begin
            s_d.chain[0] = d_n;
            for (int i = 1; i < STAGES; i++) begin
                s_d.chain[i] = s_q.chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign q_n = s_q.chain[STAGES-1];

endmodule

// File: rtl/dice_fsm.sv
module dice_fsm #(
    parameter int unsigned FACES  = 6,
    parameter int unsigned FACE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_n,
    output logic [FACE_W-1:0] face
);
    import dice_pkg::*;

    localparam logic [FACE_W-1:0] FIRST = FACE_W'(1);
    localparam logic [FACE_W-1:0] LAST  = FACE_W'(FACES);

    typedef struct packed {
        logic [FACE_W-1:0] face;
    } fsm_t;

    fsm_t f_d, f_q;
    logic held;
    logic legal;

    assign held  = (btn_n == BTN_HELD);
    assign legal = (f_q.face >= FIRST) && (f_q.face <= LAST);

    always_comb begin
        f_d = f_q;
        if (rst || !legal) begin
            f_d.face = FIRST;
        end else if (held) begin
            f_d.face = (f_q.face == LAST) ? FIRST : f_q.face + FIRST;
        end
    end

    always_ff @(posedge clk) begin
        f_q <= f_d;
    end

    assign face = f_q.face;

endmodule

// File: rtl/dice_roller.sv
module dice_roller #(
    parameter  int unsigned FACES       = 6,
    parameter  int unsigned SYNC_STAGES = 2,
    localparam int unsigned FACE_W      = $clog2(FACES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              play_n,
    output logic [FACE_W-1:0] face
);
    logic btn_sync_n;

    dice_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_n (play_n),
        .q_n (btn_sync_n)
    );

    dice_fsm #(.FACES(FACES), .FACE_W(FACE_W)) i_fsm (
        .clk   (clk),
        .rst   (rst),
        .btn_n (btn_sync_n),
        .face  (face)
    );

endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk #(
    parameter int unsigned FACES  = 6,
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         play_n,
    input logic [W-1:0] face
);
    localparam int unsigned WARM = STAGES + 1;

    logic [STAGES:0] dly;
    int unsigned     warm_cnt;

    always_ff @(posedge clk) begin
        dly <= {dly[STAGES-1:0], play_n};
        if (rst)                  warm_cnt <= 0;
        else if (warm_cnt < WARM) warm_cnt <= warm_cnt + 1;
    end

    function automatic logic [W-1:0] succ(input logic [W-1:0] f);
        return (f == W'(FACES)) ? W'(1) : f + W'(1);
    endfunction

    // R1: reset leaves face at 1
    a_r1_reset_face: assert property (@(posedge clk) rst |=> face == W'(1));

    // R2: only legal codes
    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt >= 1) |-> (face >= W'(1) && face <= W'(FACES)));

    // R3, R6: held level sampled STAGES+1 edges back causes one step
    a_r3_step_when_held: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == WARM && !dly[STAGES]) |-> face == succ($past(face)));

    // R4: wrap from the top face
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == WARM && !dly[STAGES] && $past(face) == W'(FACES)) |-> face == W'(1));

    // R5: released level keeps the value
    a_r5_hold_when_free: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == WARM && dly[STAGES]) |-> $stable(face));

endmodule

bind dice_roller dice_roller_chk #(
    .FACES  (FACES),
    .STAGES (SYNC_STAGES),
    .W      (FACE_W)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .play_n (play_n),
    .face   (face)
);

// File: tb/test_dice_roller.sv
module test_dice_roller;
    localparam int unsigned NFACE = 6;
    localparam int unsigned STG   = 2;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       play_n = 1'b1;
    logic [2:0] face;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    item_t sb[$];

    // model state of the requirements
    logic [2:0]     m_face = 3'd1;
    logic [STG-1:0] m_sync = '1;

    always #4 clk = ~clk;

    dice_roller #(.FACES(NFACE), .SYNC_STAGES(STG)) i_dice_roller (
        .clk    (clk),
        .rst    (rst),
        .play_n (play_n),
        .face   (face)
    );

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s face=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, then push the expected face after that edge
    task automatic drive(input logic pn, input logic r, input string tag);
        item_t it;
        logic stepped;
        @(negedge clk);
        play_n = pn;
        rst    = r;
        @(posedge clk);
        stepped = 1'b0;
        if (r) begin
            m_face = 3'd1;
            m_sync = '1;
        end else begin
            if (!m_sync[STG-1]) begin
                stepped = 1'b1;
                m_face = (m_face == 3'(NFACE)) ? 3'd1 : m_face + 3'd1;
            end
            m_sync = {m_sync[STG-2:0], pn};
        end
        it.exp = m_face;
        if (tag != "") it.tag = tag;
        else if (r) it.tag = "R1";
        else if (stepped && m_face == 3'd1) it.tag = "R4";
        else if (stepped) it.tag = "R3";
        else it.tag = "R5";
        sb.push_back(it);
    endtask

    // monitor: compare at the falling edge after each push
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(face, it.exp, it.tag);
                checks++;
                if (face < 3'd1 || face > 3'd6) begin
                    errors++;
                    $display("FAIL R2 face=%0d expected=1..6", face);
                end
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R1 reset
        repeat (3) drive(1'b1, 1'b1, "R1");
        // R5 idle released
        repeat (5) drive(1'b1, 1'b0, "R5");
        // R6 start latency: first two held edges give no step yet
        drive(1'b0, 1'b0, "R6");
        drive(1'b0, 1'b0, "R6");
        // R3 / R4 long hold with wraps
        repeat (14) drive(1'b0, 1'b0, "");
        // R6 release: two trailing steps, then R5 hold
        drive(1'b1, 1'b0, "R6");
        drive(1'b1, 1'b0, "R6");
        repeat (6) drive(1'b1, 1'b0, "R5");
        // R6 single-edge tap gives exactly one step
        drive(1'b0, 1'b0, "R6");
        repeat (5) drive(1'b1, 1'b0, "R6");
        // R7 reset while held, then latency again
        repeat (4) drive(1'b0, 1'b0, "");
        drive(1'b0, 1'b1, "R7");
        drive(1'b0, 1'b0, "R7");
        drive(1'b0, 1'b0, "R7");
        repeat (8) drive(1'b0, 1'b0, "R7");
        repeat (3) drive(1'b1, 1'b0, "R5");
        // R2 pseudo-random presses
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[3], 1'b0, "");
        end
        repeat (4) drive(1'b1, 1'b0, "R5");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule